// File: doc/BRIEF.md
# Isochronous DMA Transfer Terminator

This block supervises one DMA burst on an isochronous USB endpoint and decides the cycle in which that burst ends. Software starts a burst by writing the enable bit set. The same write loads a word count and sets the counter-enable and direction bits. While the burst runs, a word strobe from the DMA handshake counts the count down. An end-of-packet strobe from the USB side can end the burst early.

Three causes can end a burst. The first is clearing the enable bit. The second is an end-of-packet strobe. The third is the word count running out, and it applies only when the counter-enable bit is set and the endpoint direction is IN. An OUT endpoint never ends on the count.

When a burst ends, the block raises a one-clock end-of-transfer pulse and sets a sticky done flag. It also records the cause that won. If several causes arrive together, disable wins over end-of-packet, and end-of-packet wins over the count.

Top module: `iso_dma_term`

## Requirements
- R1: After reset, active_o, eot_o and done_o are 0, cause_o is 0 (none) and remain_o is 0.
- R2: A write with cfg_en=1 sets, on the next cycle, active_o=1, remain_o=cfg_count, done_o=0 and cause_o=0. This holds even when a burst is already active, in which case the counter is reloaded.
- R3: Each word_i strobe during an active burst lowers remain_o by one on the next cycle. At zero the counter holds at zero.
- R4: With cfg_dir_in=1 (IN) and cfg_cnt_en=1, the word strobe that takes the counter from 1 to 0 ends the burst. On the next cycle eot_o=1, done_o=1, active_o=0 and cause_o=3 (count).
- R5: With cfg_cnt_en=0, the counter reaching zero does not end the burst.
- R6: With cfg_dir_in=0 (OUT), the counter never ends the burst, whatever the value of cfg_cnt_en.
- R7: An eop_i strobe during an active burst ends it. On the next cycle eot_o=1, done_o=1 and cause_o=2 (end-of-packet).
- R8: A write with cfg_en=0 during an active burst ends it on the next cycle with eot_o=1 and cause_o=1 (disable). The same write while idle changes no output.
- R9: When causes occur in the same cycle, cause_o records disable (1) over end-of-packet (2) over count (3).
- R10: eot_o is high for exactly one clock per ending. done_o stays 1 until the next write with cfg_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit value carried by the write |
| cfg_cnt_en | input | 1 | Counter-enable bit value carried by the write |
| cfg_dir_in | input | 1 | Endpoint direction: 1 = IN, 0 = OUT |
| cfg_count | input | CNT_W | Word count loaded on an enabling write |
| eop_i | input | 1 | End-of-packet strobe from the USB side |
| word_i | input | 1 | One-word-moved strobe from the DMA handshake |
| active_o | output | 1 | Burst in progress |
| eot_o | output | 1 | One-cycle end-of-transfer pulse |
| done_o | output | 1 | Sticky burst-ended flag |
| cause_o | output | 2 | Ending cause: 0 none, 1 disable, 2 end-of-packet, 3 count |
| remain_o | output | CNT_W | Words still to move |

## Verification
The bench builds the block with CNT_W=4. At that width the largest count, 15, can be run to the end in a few cycles, so the bench checks that an IN burst ends on exactly the fifteenth word and not one word earlier. The narrow counter also makes it cheap to drive the counter to zero and past it, where it must hold, under the counter-disabled and OUT settings. The bench also provokes the three-way same-cycle collisions that decide the cause priority.

// File: rtl/iso_dma_term.sv
module iso_dma_term #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             cfg_cnt_en,
  input  logic             cfg_dir_in,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             eop_i,
  input  logic             word_i,
  output logic             active_o,
  output logic             eot_o,
  output logic             done_o,
  output logic [1:0]       cause_o,
  output logic [CNT_W-1:0] remain_o
);

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_DIS  = 2'd1;
  localparam logic [1:0] CAUSE_EOP  = 2'd2;
  localparam logic [1:0] CAUSE_CNT  = 2'd3;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             active_q, cnt_en_q, dir_in_q, done_q, eot_q;
  logic [1:0]       cause_q;
  logic [CNT_W-1:0] cnt_q;

  wire start    = cfg_wr & cfg_en;
  wire run      = active_q & ~cfg_wr;
  wire stop_dis = active_q & cfg_wr & ~cfg_en;
  wire stop_eop = run & eop_i;
  wire stop_cnt = run & word_i & (cnt_q == ONE) & cnt_en_q & dir_in_q;
  wire finish   = stop_dis | stop_eop | stop_cnt;
  wire dec      = active_q & word_i & (cnt_q != '0) & ~start;

  wire [1:0] win_cause = stop_dis ? CAUSE_DIS :
                         stop_eop ? CAUSE_EOP : CAUSE_CNT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_en_q <= 1'b0;
      dir_in_q <= 1'b0;
      done_q   <= 1'b0;
      eot_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
      cnt_q    <= '0;
    end else begin
      eot_q <= finish;
      if (start) begin
        active_q <= 1'b1;
        cnt_en_q <= cfg_cnt_en;
        dir_in_q <= cfg_dir_in;
        done_q   <= 1'b0;
        cause_q  <= CAUSE_NONE;
        cnt_q    <= cfg_count;
      end else begin
        if (dec) cnt_q <= cnt_q - ONE;
        if (finish) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          cause_q  <= win_cause;
        end
      end
    end
  end

  assign active_o = active_q;
  assign eot_o    = eot_q;
  assign done_o   = done_q;
  assign cause_o  = cause_q;
  assign remain_o = cnt_q;

endmodule

// File: rtl/iso_dma_term_chk.sv
module iso_dma_term_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_en,
  input logic [CNT_W-1:0] cfg_count,
  input logic             eop_i,
  input logic             active_o,
  input logic             eot_o,
  input logic             done_o,
  input logic [1:0]       cause_o,
  input logic [CNT_W-1:0] remain_o,
  input logic             dir_in_q,
  input logic             cnt_en_q
);

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en) |=> (active_o && !done_o && cause_o == 2'd0 && remain_o == $past(cfg_count)));

  p_count_only_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == 2'd3) |-> (dir_in_q && cnt_en_q));

  p_eop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !cfg_wr && eop_i) |=> (eot_o && cause_o == 2'd2));

  p_disable_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cfg_wr && !cfg_en) |=> (eot_o && cause_o == 2'd1));

  p_eot_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eot_o |=> !eot_o);

  p_eot_marks_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eot_o |-> (done_o && !active_o));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(cfg_wr && cfg_en)) |=> done_o);

endmodule

bind iso_dma_term iso_dma_term_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
  .cfg_count(cfg_count), .eop_i(eop_i), .active_o(active_o),
  .eot_o(eot_o), .done_o(done_o), .cause_o(cause_o), .remain_o(remain_o),
  .dir_in_q(dir_in_q), .cnt_en_q(cnt_en_q)
);

// File: tb/iso_dma_term_tb.sv
`timescale 1ns/1ps
module iso_dma_term_tb_top;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_cnt_en = 1'b0, cfg_dir_in = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic eop_i = 1'b0, word_i = 1'b0;
  logic active_o, eot_o, done_o;
  logic [1:0] cause_o;
  logic [CW-1:0] remain_o;

  int n_cmp = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iso_dma_term #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_cnt_en(cfg_cnt_en), .cfg_dir_in(cfg_dir_in), .cfg_count(cfg_count),
    .eop_i(eop_i), .word_i(word_i), .active_o(active_o), .eot_o(eot_o),
    .done_o(done_o), .cause_o(cause_o), .remain_o(remain_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic state(input string tag, input int act, input int eot, input int done,
                       input int cause, input int rem);
    chk({tag, " active"}, int'(active_o), act);
    chk({tag, " eot"},    int'(eot_o), eot);
    chk({tag, " done"},   int'(done_o), done);
    chk({tag, " cause"},  int'(cause_o), cause);
    chk({tag, " remain"}, int'(remain_o), rem);
  endtask

  task automatic write(input bit en, input bit cen, input bit din, input int cnt);
    cfg_wr = 1'b1; cfg_en = en; cfg_cnt_en = cen; cfg_dir_in = din; cfg_count = CW'(cnt);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_en = 1'b0;
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) begin
      word_i = 1'b1;
      @(negedge clk);
      word_i = 1'b0;
    end
  endtask

  task automatic eop();
    eop_i = 1'b1;
    @(negedge clk);
    eop_i = 1'b0;
  endtask

  task automatic t_reset();
    state("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_count_in();
    write(1, 1, 1, 5);
    state("R2 load", 1, 0, 0, 0, 5);
    words(1);
    chk("R3 decrement", int'(remain_o), 4);
    words(3);
    state("R4 before last", 1, 0, 0, 0, 1);
    words(1);
    state("R4 count end", 0, 1, 1, 3, 0);
    @(negedge clk);
    state("R10 pulse drop", 0, 0, 1, 3, 0);
  endtask

  task automatic t_no_cnt_en();
    write(1, 0, 1, 2);
    chk("R10 done cleared by start", int'(done_o), 0);
    words(2);
    state("R5 zero no end", 1, 0, 0, 0, 0);
    words(1);
    chk("R3 hold at zero", int'(remain_o), 0);
    eop();
    state("R7 eop end", 0, 1, 1, 2, 0);
  endtask

  task automatic t_out();
    write(1, 1, 0, 3);
    words(3);
    state("R6 out ignores count", 1, 0, 0, 0, 0);
    write(0, 0, 0, 0);
    state("R8 disable end", 0, 1, 1, 1, 0);
    @(negedge clk);
    write(0, 0, 0, 7);
    state("R8 idle disable no effect", 0, 0, 1, 1, 0);
  endtask

  task automatic t_reload();
    write(1, 1, 1, 6);
    words(2);
    chk("R3 after two words", int'(remain_o), 4);
    write(1, 1, 1, 9);
    state("R2 reload active", 1, 0, 0, 0, 9);
    write(0, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_prio();
    write(1, 1, 1, 1);
    cfg_wr = 1'b1; cfg_en = 1'b0; eop_i = 1'b1; word_i = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; eop_i = 1'b0; word_i = 1'b0;
    chk("R9 disable wins", int'(cause_o), 1);
    @(negedge clk);
    write(1, 1, 1, 1);
    eop_i = 1'b1; word_i = 1'b1;
    @(negedge clk);
    eop_i = 1'b0; word_i = 1'b0;
    chk("R9 eop over count", int'(cause_o), 2);
    @(negedge clk);
    write(1, 1, 1, 1);
    words(1);
    chk("R9 count alone", int'(cause_o), 3);
    @(negedge clk);
  endtask

  task automatic t_max();
    write(1, 1, 1, 15);
    words(14);
    state("R4 max minus one", 1, 0, 0, 0, 1);
    words(1);
    state("R4 max end", 0, 1, 1, 3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_in();
    t_no_cnt_en();
    t_out();
    t_reload();
    t_prio();
    t_max();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule